// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt a hart should take next. Each cycle it looks at the pending and enable vectors, the delegation mask, the current privilege level and the global enable bits for machine and supervisor level. From these it picks the eligible interrupt with the lowest bit index and presents the choice one clock later as a valid flag and an index. When nothing qualifies it reports an explicit "none": the valid flag is low.

Whether an interrupt is eligible depends on where it is delegated. Interrupts that are not delegated are gated by the machine-level gate. Delegated interrupts are gated by the supervisor-level gate. A virtualization input enables a second path. In that mode, host-level interrupts gated by the hypervisor's own supervisor enable are served first, and raise a flag that forces the trap to the hypervisor. Only when none of those qualify does the block look at the guest interrupt bits.

Top module: `irq_pick_sel`

## Requirements
- R1: The candidate set is pending AND enable, bit by bit. A bit that is pending but not enabled, or enabled but not pending, is never selected. If no candidate qualifies, the output reads "none".
- R2: A candidate whose delegation bit is 0 qualifies only when the machine gate is open. The machine gate is open when privilege is below machine, or when privilege is machine and `m_ie_i` is 1.
- R3: A candidate whose delegation bit is 1 qualifies only when the supervisor gate is open. The supervisor gate is open when privilege is user, or when privilege is supervisor and `s_ie_i` is 1. It is closed at machine level.
- R4: `priv_i` encodes user as 0, supervisor as 1 and machine as 3. The value 2 behaves exactly as user.
- R5: Among the qualified interrupts, the lowest bit index is selected. Index 0 and index NUM_IRQ-1 are both reachable.
- R6: The "none" indication is `sel_valid_o` = 0, with `sel_idx_o` = 0 and `force_hyp_o` = 0.
- R7: With `virt_i` = 0, the guest bits are never candidates. These are the bits set in GUEST_MASK, which by default are bits 2, 6 and 10.
- R8: With `virt_i` = 1, the block first checks the non-guest candidates against the hypervisor gate. That gate opens when privilege is below supervisor, or when privilege is supervisor and `hs_ie_i` is 1. Delegation does not apply here. If any such candidate exists, the lowest one is selected and `force_hyp_o` = 1.
- R9: With `virt_i` = 1 and no candidate under R8, only the guest candidates are considered. They use the delegation gating of R2 and R3, and `force_hyp_o` = 0.
- R10: The outputs are registered. They reflect the inputs sampled at the previous rising edge. A synchronous active-high `rst` sets them to "none".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Pending interrupt bits |
| enab_i | input | NUM_IRQ | Interrupt enable bits |
| deleg_i | input | NUM_IRQ | Delegation mask (1 = delegated to supervisor) |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 2 as U, 3 M) |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| virt_i | input | 1 | Hart runs a guest |
| hs_ie_i | input | 1 | Hypervisor-level supervisor interrupt enable |
| sel_valid_o | output | 1 | An interrupt was selected |
| sel_idx_o | output | IDX_W | Index of the selected interrupt |
| force_hyp_o | output | 1 | Selection must trap to the hypervisor |

## Verification
The bench builds the block with its defaults: 16 interrupt lines, with guest bits at 2, 6 and 10. Sixteen lines are enough to place guest and host interrupts side by side. This lets the bench show that the host-first rule in virtualized mode beats a lower-numbered guest bit. It also lets the bench reach both ends of the index range. The bench walks all four privilege encodings against each gate. This includes the reserved value 2, the machine level with its enable cleared, and the supervisor level with its enable cleared.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } priv_e;

  // Reserved encoding collapses onto user level
  function automatic priv_e fold_priv(input logic [1:0] raw);
    priv_e p;
    p = priv_e'(raw);
    if (p == PRV_RSVD) p = PRV_USER;
    return p;
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_ie_i,
  input  logic       s_ie_i,
  input  logic       hs_ie_i,
  output logic       m_open_o,
  output logic       s_open_o,
  output logic       hs_open_o
);
  priv_e lvl;

  always_comb begin
    lvl       = fold_priv(priv_i);
    m_open_o  = (lvl != PRV_MACH) || m_ie_i;
    s_open_o  = (lvl == PRV_USER) || ((lvl == PRV_SUPER) && s_ie_i);
    hs_open_o = (lvl == PRV_USER) || ((lvl == PRV_SUPER) && hs_ie_i);
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int              NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] GUEST_MASK = 16'h0444
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enab_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic               virt_i,
  input  logic               m_open_i,
  input  logic               s_open_i,
  input  logic               hs_open_i,
  output logic [NUM_IRQ-1:0] qual_o,
  output logic               force_o
);
  logic [NUM_IRQ-1:0] cand, host, guest, hs_hits, pool, via_m, via_s;

  always_comb begin
    cand    = pend_i & enab_i;
    host    = cand & ~GUEST_MASK;
    guest   = cand & GUEST_MASK;
    hs_hits = host & {NUM_IRQ{hs_open_i}};
    force_o = virt_i && (hs_hits != '0);
    pool    = virt_i ? guest : host;
    via_m   = pool & ~deleg_i & {NUM_IRQ{m_open_i}};
    via_s   = pool &  deleg_i & {NUM_IRQ{s_open_i}};
    qual_o  = force_o ? hs_hits : (via_m | via_s);
  end
endmodule

// File: rtl/lowest_bit_find.sv
module lowest_bit_find #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pick_sel.sv
module irq_pick_sel #(
  parameter int                 NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] GUEST_MASK = 16'h0444,
  localparam int                IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enab_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_ie_i,
  input  logic               s_ie_i,
  input  logic               virt_i,
  input  logic               hs_ie_i,
  output logic               sel_valid_o,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               force_hyp_o
);
  logic               m_open, s_open, hs_open;
  logic [NUM_IRQ-1:0] qual;
  logic               force_c, found;
  logic [IDX_W-1:0]   idx_c;

  irq_gate u_gate (
    .priv_i    (priv_i),
    .m_ie_i    (m_ie_i),
    .s_ie_i    (s_ie_i),
    .hs_ie_i   (hs_ie_i),
    .m_open_o  (m_open),
    .s_open_o  (s_open),
    .hs_open_o (hs_open)
  );

  irq_qualify #(.NUM_IRQ(NUM_IRQ), .GUEST_MASK(GUEST_MASK)) u_qual (
    .pend_i    (pend_i),
    .enab_i    (enab_i),
    .deleg_i   (deleg_i),
    .virt_i    (virt_i),
    .m_open_i  (m_open),
    .s_open_i  (s_open),
    .hs_open_i (hs_open),
    .qual_o    (qual),
    .force_o   (force_c)
  );

  lowest_bit_find #(.NUM_IRQ(NUM_IRQ)) u_find (
    .vec_i   (qual),
    .found_o (found),
    .idx_o   (idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
      force_hyp_o <= 1'b0;
    end else begin
      sel_valid_o <= found;
      sel_idx_o   <= found ? idx_c : '0;
      force_hyp_o <= found && force_c;
    end
  end

  // R1: a selected line was both pending and enabled at the sampling edge
  assert_sel_is_cand_R1: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> (((($past(pend_i) & $past(enab_i)) >> sel_idx_o) & NUM_IRQ'(1)) != '0));

  // R1: empty candidate set yields no selection
  assert_empty_none_R1: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_i) & $past(enab_i)) == '0) |-> !sel_valid_o);

  // R6: the none indication carries zero index and no force flag
  assert_none_clean_R6: assert property (@(posedge clk) disable iff (rst)
    !sel_valid_o |-> (sel_idx_o == '0) && !force_hyp_o);

  // R7: guest lines are out of reach outside virtualized mode
  assert_no_guest_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && !$past(virt_i)) |-> (((GUEST_MASK >> sel_idx_o) & NUM_IRQ'(1)) == '0));

  // R8: forced hypervisor trap only in virtualized mode, on a host line
  assert_force_host_R8: assert property (@(posedge clk) disable iff (rst)
    force_hyp_o |-> $past(virt_i) && (((GUEST_MASK >> sel_idx_o) & NUM_IRQ'(1)) == '0));

  // R2: machine level with its enable clear never takes an undelegated line
  assert_m_closed_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_valid_o && !$past(virt_i) && ($past(priv_i) == 2'd3) && !$past(m_ie_i))
      |-> ((($past(deleg_i) >> sel_idx_o) & NUM_IRQ'(1)) != '0));
endmodule

// File: tb/irq_pick_sel_tb.sv
module irq_pick_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int IW = 4;

  typedef struct packed {
    logic [N-1:0] pend;
    logic [N-1:0] en;
    logic [N-1:0] dg;
    logic [1:0]   priv;
    logic         mie, sie, virt, hsie;
    logic         ev;
    logic [IW-1:0] ei;
    logic         ef;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    // pend     en        dg     pr  mi si vi hs  ev ei  ef req
    '{16'h0088,16'h0000,16'h0000,2'd0,1'b1,1'b1,1'b0,1'b0, 1'b0,4'd0, 1'b0,8'd1},  // R1 not enabled
    '{16'h0088,16'h0080,16'h0000,2'd3,1'b1,1'b0,1'b0,1'b0, 1'b1,4'd7, 1'b0,8'd2},  // R2 M open
    '{16'h0088,16'h0080,16'h0000,2'd3,1'b0,1'b1,1'b0,1'b0, 1'b0,4'd0, 1'b0,8'd2},  // R2 M closed
    '{16'h0080,16'hFFFF,16'h0000,2'd1,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd7, 1'b0,8'd2},  // R2 below M
    '{16'h0020,16'hFFFF,16'h0020,2'd1,1'b1,1'b0,1'b0,1'b0, 1'b0,4'd0, 1'b0,8'd3},  // R3 S closed
    '{16'h0020,16'hFFFF,16'h0020,2'd1,1'b0,1'b1,1'b0,1'b0, 1'b1,4'd5, 1'b0,8'd3},  // R3 S open
    '{16'h0020,16'hFFFF,16'h0020,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd5, 1'b0,8'd3},  // R3 user
    '{16'h0020,16'hFFFF,16'h0020,2'd3,1'b1,1'b1,1'b0,1'b0, 1'b0,4'd0, 1'b0,8'd3},  // R3 at M
    '{16'h0020,16'hFFFF,16'h0020,2'd2,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd5, 1'b0,8'd4},  // R4 rsvd=U
    '{16'h0080,16'hFFFF,16'h0000,2'd2,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd7, 1'b0,8'd4},  // R4 rsvd=U
    '{16'hF0A0,16'hFFFF,16'h0000,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd5, 1'b0,8'd5},  // R5 lowest
    '{16'h8000,16'hFFFF,16'h0000,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd15,1'b0,8'd5},  // R5 top
    '{16'h0001,16'hFFFF,16'h0000,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd0, 1'b0,8'd5},  // R5 bottom
    '{16'h00A0,16'hFFFF,16'h0020,2'd1,1'b0,1'b0,1'b0,1'b0, 1'b1,4'd7, 1'b0,8'd5},  // R5 skip gated
    '{16'h0444,16'hFFFF,16'h0000,2'd0,1'b1,1'b1,1'b0,1'b1, 1'b0,4'd0, 1'b0,8'd7},  // R7 guest only
    '{16'h0448,16'hFFFF,16'h0000,2'd0,1'b1,1'b1,1'b0,1'b1, 1'b1,4'd3, 1'b0,8'd7},  // R7 host past guest
    '{16'h0C44,16'hFFFF,16'h0000,2'd0,1'b0,1'b0,1'b1,1'b0, 1'b1,4'd11,1'b1,8'd8},  // R8 host first
    '{16'h0C44,16'hFFFF,16'h0000,2'd1,1'b0,1'b0,1'b1,1'b0, 1'b1,4'd2, 1'b0,8'd9},  // R9 guest path
    '{16'h0C44,16'hFFFF,16'hFFFF,2'd1,1'b0,1'b0,1'b1,1'b1, 1'b1,4'd11,1'b1,8'd8},  // R8 deleg ignored
    '{16'h0C44,16'hFFFF,16'h0004,2'd1,1'b0,1'b0,1'b1,1'b0, 1'b1,4'd6, 1'b0,8'd9},  // R9 gated guest
    '{16'h0800,16'hFFFF,16'h0000,2'd3,1'b0,1'b1,1'b1,1'b1, 1'b0,4'd0, 1'b0,8'd8},  // R8 closed at M
    '{16'h0040,16'hFFFF,16'h0000,2'd3,1'b1,1'b0,1'b1,1'b1, 1'b1,4'd6, 1'b0,8'd9}   // R9 guest at M
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pend = '0, en = '0, dg = '0;
  logic [1:0] priv = '0;
  logic mie = 0, sie = 0, virt = 0, hsie = 0;
  logic valid, force_h;
  logic [IW-1:0] idx;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pick_sel u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .enab_i(en), .deleg_i(dg),
    .priv_i(priv), .m_ie_i(mie), .s_ie_i(sie), .virt_i(virt), .hs_ie_i(hsie),
    .sel_valid_o(valid), .sel_idx_o(idx), .force_hyp_o(force_h)
  );

  task automatic check(input string tag, input logic ev, input logic [IW-1:0] ei, input logic ef);
    checks++;
    if (valid !== ev || idx !== ei || force_h !== ef) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d force=%0b, expected valid=%0b idx=%0d force=%0b",
               tag, valid, idx, force_h, ev, ei, ef);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    pend = v.pend; en = v.en; dg = v.dg; priv = v.priv;
    mie = v.mie; sie = v.sie; virt = v.virt; hsie = v.hsie;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset none", 1'b0, '0, 1'b0);
    @(negedge clk) rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k]);
      @(posedge clk); #1;
      check($sformatf("R%0d row %0d", TBL[k].req, k), TBL[k].ev, TBL[k].ei, TBL[k].ef);
    end

    // R10: outputs hold until the next rising edge
    drive(TBL[12]);
    @(posedge clk); #1;
    drive(TBL[11]);
    #1;
    check("R10 held before edge", 1'b1, 4'd0, 1'b0);
    @(posedge clk); #1;
    check("R10 updated after edge", 1'b1, 4'd15, 1'b0);

    // R10 / R6: synchronous reset forces none with a live candidate
    @(negedge clk) rst = 1'b1;
    #1;
    check("R10 reset is synchronous", 1'b1, 4'd15, 1'b0);
    @(posedge clk); #1;
    check("R6 reset clears", 1'b0, '0, 1'b0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R10 resumes", 1'b1, 4'd15, 1'b0);

    // R8: forced selection also clears through reset
    drive(TBL[16]);
    @(posedge clk); #1;
    check("R8 force set", 1'b1, 4'd11, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R6 force cleared by reset", 1'b0, '0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule